// File: doc/BRIEF.md
# Write-Once Chunk Store Controller

This block owns a small on-chip pool of fixed-size chunks, each sixteen 64-bit words, and enforces a write-once discipline on them. A requester asks for a fresh handle, fills the chunk word by word, and seals it. After sealing the chunk is read-only and readable by any task that knows the handle. Before sealing, only the task that allocated the chunk may touch it. Each word is stored together with a four-bit type tag. Each chunk also keeps a kind code, an owner task number, a sealed flag and a reference count.

Requests arrive one at a time on a valid/ready port. Each accepted request produces exactly one registered response that carries a status code and a result. When a decrement drops a chunk's reference count to zero, the chunk's handle returns to the free pool. The block then walks the freed chunk's words and emits one decrement request on a separate output stream for every word tagged as a handle. That stream lets the requester carry collection one level further.

Top module: `wrOnceChunkStore`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0 and decValid is 0.
- R2: Allocate (op 0) returns status OK (0) with the lowest-numbered unused handle in rspData. When all 64 handles are in use, it returns status FULL (4).
- R3: Write (op 1) by the owning task to an unsealed chunk returns OK. Read (op 3) by the owner returns the stored word in rspData, its tag in rspTag and the chunk kind given at allocation in rspKind.
- R4: A write or a seal (op 2) by a task that is not the owner returns DENIED (3). A write to a sealed chunk also returns DENIED. In every such case the stored word stays unchanged.
- R5: A read of an unsealed chunk by a task that is not the owner returns DENIED. Once the chunk is sealed, any task may read it.
- R6: Any request other than allocate returns BADHANDLE (1) when handle bits 63..6 are not all zero. It returns NOTALLOC (2) when the handle is not in use. An op code above 5 returns BADOP (5).
- R7: The first write after allocation sets the reference count to 1. Increment (op 4) and decrement (op 5) each return the new count in rspData.
- R8: A decrement that leaves the count at zero frees the handle. A later read of that handle returns NOTALLOC, and the handle is again available to allocate.
- R9: After a chunk is freed, each of its words whose tag has bit 2 or bit 3 set (handle flags) is presented on decHandle with decValid, in ascending word order. Each one is held until decReady is 1. Words tagged only as data (bits 0 and 1) are skipped. reqReady stays 0 for the whole walk.
- R10: rspValid is 1 in exactly the cycle after a request is accepted, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted |
| reqOp | input | 3 | Operation code |
| reqTask | input | TASK_W | Requesting task number |
| reqHandle | input | HANDLE_W | Target handle |
| reqWord | input | log2(WORDS) | Word index inside the chunk |
| reqData | input | DATA_W | Word to write |
| reqTag | input | TAG_W | Tag to write with the word |
| reqKind | input | KIND_W | Chunk kind for allocation |
| rspValid | output | 1 | Response present |
| rspStatus | output | 3 | Status code |
| rspData | output | DATA_W | Handle, word or count |
| rspTag | output | TAG_W | Tag of the word read |
| rspKind | output | KIND_W | Kind of the chunk read |
| decValid | output | 1 | Follow-on decrement request present |
| decReady | input | 1 | Follow-on decrement taken |
| decHandle | output | DATA_W | Handle word to decrement |

## Verification
The block registers every response once, so the result of a request accepted at a rising edge is due in the very next cycle. The bench drives requests on falling edges and reads the response at the falling edge that follows the accepting rising edge. Follow-on decrements come out a variable number of cycles after the freeing response, because data-only words are skipped at one per cycle. The bench therefore polls decValid on falling edges within a bounded window, and it checks that a word held back by decReady stays put across several cycles.

// File: rtl/csPkg.sv
package csPkg;
  localparam logic [2:0] OP_ALLOC = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_SEAL  = 3'd2;
  localparam logic [2:0] OP_READ  = 3'd3;
  localparam logic [2:0] OP_INCR  = 3'd4;
  localparam logic [2:0] OP_DECR  = 3'd5;

  localparam logic [2:0] ST_OK        = 3'd0;
  localparam logic [2:0] ST_BADHANDLE = 3'd1;
  localparam logic [2:0] ST_NOTALLOC  = 3'd2;
  localparam logic [2:0] ST_DENIED    = 3'd3;
  localparam logic [2:0] ST_FULL      = 3'd4;
  localparam logic [2:0] ST_BADOP     = 3'd5;

  // tag bit positions: two data halves, two handle halves
  localparam int TAG_LDATA   = 0;
  localparam int TAG_RDATA   = 1;
  localparam int TAG_LHANDLE = 2;
  localparam int TAG_RHANDLE = 3;

  typedef struct packed {
    logic doAlloc;
    logic doWrite;
    logic doSeal;
    logic doIncr;
    logic doDecr;
    logic doFree;
  } ctrlStrobeT;
endpackage

// File: rtl/csDatapath.sv
module csDatapath
  import csPkg::*;
#(
  parameter int CHUNKS = 64,
  parameter int WORDS  = 16,
  parameter int DATA_W = 64,
  parameter int TASK_W = 8,
  parameter int CNT_W  = 8,
  parameter int KIND_W = 2,
  parameter int TAG_W  = 4,
  localparam int IDX_W  = $clog2(CHUNKS),
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [IDX_W-1:0]  selIdx,
  input  logic [WIDX_W-1:0] wordIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [TASK_W-1:0] newOwner,
  input  logic [KIND_W-1:0] newKind,
  output logic              selInUse,
  output logic              selSealed,
  output logic [TASK_W-1:0] selOwner,
  output logic [CNT_W-1:0]  selCount,
  output logic [KIND_W-1:0] selKind,
  output logic [DATA_W-1:0] rdData,
  output logic [TAG_W-1:0]  rdTag,
  output logic              freeAvail,
  output logic [IDX_W-1:0]  freeIdx
);
  localparam int ADDR_W = IDX_W + WIDX_W;
  localparam int TVEC_W = WORDS * TAG_W;

  logic [DATA_W-1:0] wordMem [CHUNKS*WORDS];
  logic [CHUNKS-1:0] inUseMap;
  logic [CHUNKS-1:0] sealedMap;
  logic [TASK_W-1:0] ownerArr [CHUNKS];
  logic [CNT_W-1:0]  cntArr   [CHUNKS];
  logic [KIND_W-1:0] kindArr  [CHUNKS];
  logic [TVEC_W-1:0] tagArr   [CHUNKS];

  logic [ADDR_W-1:0] wordAddr;
  assign wordAddr = {selIdx, wordIdx};

  // word storage has no reset; tags decide what is meaningful
  always_ff @(posedge clk) begin
    if (strobe.doWrite) wordMem[wordAddr] <= wrData;
  end

  for (genvar i = 0; i < CHUNKS; i++) begin : gChunk
    logic              hit;
    logic              inUseR, sealedR, touchedR;
    logic [TASK_W-1:0] ownerR;
    logic [CNT_W-1:0]  cntR;
    logic [KIND_W-1:0] kindR;
    logic [TVEC_W-1:0] tagR;

    assign hit = (selIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        inUseR   <= 1'b0;
        sealedR  <= 1'b0;
        touchedR <= 1'b0;
        ownerR   <= '0;
        cntR     <= '0;
        kindR    <= '0;
        tagR     <= '0;
      end else if (hit) begin
        if (strobe.doAlloc) begin
          inUseR   <= 1'b1;
          sealedR  <= 1'b0;
          touchedR <= 1'b0;
          ownerR   <= newOwner;
          cntR     <= '0;
          kindR    <= newKind;
          tagR     <= '0;
        end
        if (strobe.doWrite) begin
          tagR[wordIdx*TAG_W +: TAG_W] <= wrTag;
          if (!touchedR) begin
            touchedR <= 1'b1;
            cntR     <= CNT_W'(cntR + 1'b1);
          end
        end
        if (strobe.doSeal) sealedR <= 1'b1;
        if (strobe.doIncr && (cntR != '1)) cntR <= CNT_W'(cntR + 1'b1);
        if (strobe.doDecr && (cntR != '0)) cntR <= CNT_W'(cntR - 1'b1);
        if (strobe.doFree) begin
          inUseR <= 1'b0;
          cntR   <= '0;
        end
      end
    end

    assign inUseMap[i]  = inUseR;
    assign sealedMap[i] = sealedR;
    assign ownerArr[i]  = ownerR;
    assign cntArr[i]    = cntR;
    assign kindArr[i]   = kindR;
    assign tagArr[i]    = tagR;
  end

  assign selInUse  = inUseMap[selIdx];
  assign selSealed = sealedMap[selIdx];
  assign selOwner  = ownerArr[selIdx];
  assign selCount  = cntArr[selIdx];
  assign selKind   = kindArr[selIdx];
  assign rdData    = wordMem[wordAddr];
  assign rdTag     = tagArr[selIdx][wordIdx*TAG_W +: TAG_W];

  // lowest free handle: scan from the top so the smallest index wins
  always_comb begin
    freeIdx   = '0;
    freeAvail = ~&inUseMap;
    for (int k = CHUNKS - 1; k >= 0; k--) begin
      if (!inUseMap[k]) freeIdx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/csControl.sv
module csControl
  import csPkg::*;
#(
  parameter int CHUNKS   = 64,
  parameter int WORDS    = 16,
  parameter int DATA_W   = 64,
  parameter int HANDLE_W = 64,
  parameter int TASK_W   = 8,
  parameter int CNT_W    = 8,
  parameter int KIND_W   = 2,
  parameter int TAG_W    = 4,
  localparam int IDX_W  = $clog2(CHUNKS),
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [2:0]          reqOp,
  input  logic [TASK_W-1:0]   reqTask,
  input  logic [HANDLE_W-1:0] reqHandle,
  input  logic [WIDX_W-1:0]   reqWord,
  output ctrlStrobeT          strobe,
  output logic [IDX_W-1:0]    selIdx,
  output logic [WIDX_W-1:0]   wordIdx,
  input  logic                selInUse,
  input  logic                selSealed,
  input  logic [TASK_W-1:0]   selOwner,
  input  logic [CNT_W-1:0]    selCount,
  input  logic [KIND_W-1:0]   selKind,
  input  logic [DATA_W-1:0]   rdData,
  input  logic [TAG_W-1:0]    rdTag,
  input  logic                freeAvail,
  input  logic [IDX_W-1:0]    freeIdx,
  output logic                rspValid,
  output logic [2:0]          rspStatus,
  output logic [DATA_W-1:0]   rspData,
  output logic [TAG_W-1:0]    rspTag,
  output logic [KIND_W-1:0]   rspKind,
  output logic                decValid,
  input  logic                decReady,
  output logic [DATA_W-1:0]   decHandle
);
  typedef enum logic {S_IDLE, S_WALK} stateT;

  stateT             state;
  logic [IDX_W-1:0]  walkIdx;
  logic [WIDX_W-1:0] walkWord;

  logic              accept, badHandle, isOwner, startWalk, walkStep;
  ctrlStrobeT        want;
  logic [2:0]        nStatus;
  logic [DATA_W-1:0] nData;
  logic [TAG_W-1:0]  nTag;
  logic [KIND_W-1:0] nKind;
  logic [CNT_W-1:0]  upCount, downCount;

  assign reqReady  = (state == S_IDLE);
  assign accept    = reqValid && reqReady;
  assign badHandle = |reqHandle[HANDLE_W-1:IDX_W];
  assign isOwner   = (selOwner == reqTask);
  assign upCount   = (selCount == '1) ? selCount : CNT_W'(selCount + 1'b1);
  assign downCount = (selCount == '0) ? '0 : CNT_W'(selCount - 1'b1);

  always_comb begin
    if (state == S_WALK) begin
      selIdx  = walkIdx;
      wordIdx = walkWord;
    end else begin
      selIdx  = (reqOp == OP_ALLOC) ? freeIdx : reqHandle[IDX_W-1:0];
      wordIdx = reqWord;
    end
  end

  // request decode: outcome and the datapath strobes it asks for
  always_comb begin
    want      = '0;
    nStatus   = ST_OK;
    nData     = '0;
    nTag      = '0;
    nKind     = '0;
    startWalk = 1'b0;
    if (reqOp > OP_DECR) begin
      nStatus = ST_BADOP;
    end else if (reqOp == OP_ALLOC) begin
      if (freeAvail) begin
        want.doAlloc = 1'b1;
        nData        = DATA_W'(freeIdx);
      end else begin
        nStatus = ST_FULL;
      end
    end else if (badHandle) begin
      nStatus = ST_BADHANDLE;
    end else if (!selInUse) begin
      nStatus = ST_NOTALLOC;
    end else begin
      case (reqOp)
        OP_WRITE: begin
          if (selSealed || !isOwner) nStatus = ST_DENIED;
          else want.doWrite = 1'b1;
        end
        OP_SEAL: begin
          if (selSealed || !isOwner) nStatus = ST_DENIED;
          else want.doSeal = 1'b1;
        end
        OP_READ: begin
          if (!selSealed && !isOwner) begin
            nStatus = ST_DENIED;
          end else begin
            nData = rdData;
            nTag  = rdTag;
            nKind = selKind;
          end
        end
        OP_INCR: begin
          want.doIncr = 1'b1;
          nData       = DATA_W'(upCount);
        end
        default: begin
          want.doDecr = 1'b1;
          nData       = DATA_W'(downCount);
          if (downCount == '0) begin
            want.doFree = 1'b1;
            startWalk   = 1'b1;
          end
        end
      endcase
    end
  end

  assign strobe = accept ? want : '0;

  // walk over a freed chunk, one word per cycle unless a handle waits
  assign decValid  = (state == S_WALK) && (rdTag[TAG_LHANDLE] || rdTag[TAG_RHANDLE]);
  assign decHandle = rdData;
  assign walkStep  = !decValid || decReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      walkIdx  <= '0;
      walkWord <= '0;
    end else if (state == S_IDLE) begin
      if (accept && startWalk) begin
        state    <= S_WALK;
        walkIdx  <= reqHandle[IDX_W-1:0];
        walkWord <= '0;
      end
    end else if (walkStep) begin
      if (walkWord == WIDX_W'(WORDS - 1)) state <= S_IDLE;
      walkWord <= WIDX_W'(walkWord + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspStatus <= ST_OK;
      rspData   <= '0;
      rspTag    <= '0;
      rspKind   <= '0;
    end else begin
      rspValid <= accept;
      if (accept) begin
        rspStatus <= nStatus;
        rspData   <= nData;
        rspTag    <= nTag;
        rspKind   <= nKind;
      end
    end
  end
endmodule

// File: rtl/wrOnceChunkStore.sv
module wrOnceChunkStore
  import csPkg::*;
#(
  parameter int CHUNKS   = 64,
  parameter int WORDS    = 16,
  parameter int DATA_W   = 64,
  parameter int HANDLE_W = 64,
  parameter int TASK_W   = 8,
  parameter int CNT_W    = 8,
  parameter int KIND_W   = 2,
  parameter int TAG_W    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [2:0]                 reqOp,
  input  logic [TASK_W-1:0]          reqTask,
  input  logic [HANDLE_W-1:0]        reqHandle,
  input  logic [$clog2(WORDS)-1:0]   reqWord,
  input  logic [DATA_W-1:0]          reqData,
  input  logic [TAG_W-1:0]           reqTag,
  input  logic [KIND_W-1:0]          reqKind,
  output logic                       rspValid,
  output logic [2:0]                 rspStatus,
  output logic [DATA_W-1:0]          rspData,
  output logic [TAG_W-1:0]           rspTag,
  output logic [KIND_W-1:0]          rspKind,
  output logic                       decValid,
  input  logic                       decReady,
  output logic [DATA_W-1:0]          decHandle
);
  localparam int IDX_W  = $clog2(CHUNKS);
  localparam int WIDX_W = $clog2(WORDS);

  ctrlStrobeT        strobe;
  logic [IDX_W-1:0]  selIdx, freeIdx;
  logic [WIDX_W-1:0] wordIdx;
  logic              selInUse, selSealed, freeAvail;
  logic [TASK_W-1:0] selOwner;
  logic [CNT_W-1:0]  selCount;
  logic [KIND_W-1:0] selKind;
  logic [DATA_W-1:0] rdData;
  logic [TAG_W-1:0]  rdTag;

  csControl #(
    .CHUNKS(CHUNKS), .WORDS(WORDS), .DATA_W(DATA_W), .HANDLE_W(HANDLE_W),
    .TASK_W(TASK_W), .CNT_W(CNT_W), .KIND_W(KIND_W), .TAG_W(TAG_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqTask(reqTask), .reqHandle(reqHandle), .reqWord(reqWord),
    .strobe(strobe), .selIdx(selIdx), .wordIdx(wordIdx),
    .selInUse(selInUse), .selSealed(selSealed), .selOwner(selOwner),
    .selCount(selCount), .selKind(selKind), .rdData(rdData), .rdTag(rdTag),
    .freeAvail(freeAvail), .freeIdx(freeIdx),
    .rspValid(rspValid), .rspStatus(rspStatus), .rspData(rspData),
    .rspTag(rspTag), .rspKind(rspKind),
    .decValid(decValid), .decReady(decReady), .decHandle(decHandle)
  );

  csDatapath #(
    .CHUNKS(CHUNKS), .WORDS(WORDS), .DATA_W(DATA_W), .TASK_W(TASK_W),
    .CNT_W(CNT_W), .KIND_W(KIND_W), .TAG_W(TAG_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selIdx(selIdx), .wordIdx(wordIdx),
    .wrData(reqData), .wrTag(reqTag), .newOwner(reqTask), .newKind(reqKind),
    .selInUse(selInUse), .selSealed(selSealed), .selOwner(selOwner),
    .selCount(selCount), .selKind(selKind), .rdData(rdData), .rdTag(rdTag),
    .freeAvail(freeAvail), .freeIdx(freeIdx)
  );
endmodule

// File: rtl/wrOnceChunkStoreChk.sv
module wrOnceChunkStoreChk #(
  parameter int CHUNKS   = 64,
  parameter int WORDS    = 16,
  parameter int DATA_W   = 64,
  parameter int HANDLE_W = 64,
  parameter int TASK_W   = 8,
  parameter int KIND_W   = 2,
  parameter int TAG_W    = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     reqValid,
  input logic                     reqReady,
  input logic [2:0]               reqOp,
  input logic [HANDLE_W-1:0]      reqHandle,
  input logic                     rspValid,
  input logic [2:0]               rspStatus,
  input logic [DATA_W-1:0]        rspData,
  input logic                     decValid,
  input logic                     decReady,
  input logic [DATA_W-1:0]        decHandle
);
  localparam int IDX_W = $clog2(CHUNKS);

  p_rsp_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  p_no_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid);

  p_bad_handle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp != 3'd0 && reqOp <= 3'd5 &&
     (|reqHandle[HANDLE_W-1:IDX_W])) |=> (rspStatus == 3'd1));

  p_alloc_in_pool_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == 3'd0) |=>
    (rspStatus != 3'd0 || rspData < DATA_W'(CHUNKS)));

  p_walk_blocks_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> !reqReady);

  p_dec_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decReady) |=> (decValid && $stable(decHandle)));
endmodule

bind wrOnceChunkStore wrOnceChunkStoreChk #(
  .CHUNKS(CHUNKS), .WORDS(WORDS), .DATA_W(DATA_W), .HANDLE_W(HANDLE_W),
  .TASK_W(TASK_W), .KIND_W(KIND_W), .TAG_W(TAG_W)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqOp(reqOp), .reqHandle(reqHandle), .rspValid(rspValid),
  .rspStatus(rspStatus), .rspData(rspData), .decValid(decValid),
  .decReady(decReady), .decHandle(decHandle)
);

// File: tb/tb_wrOnceChunkStore.sv
module tb_wrOnceChunkStore;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  reqNum;
    logic [2:0]  op;
    logic [7:0]  tsk;
    logic [63:0] handle;
    logic [3:0]  word;
    logic [63:0] data;
    logic [3:0]  tag;
    logic [1:0]  kind;
    logic [2:0]  expStatus;
    logic [63:0] expData;
  } vecT;

  // op: 0 alloc 1 write 2 seal 3 read 4 incr 5 decr
  // status: 0 ok 1 badhandle 2 notalloc 3 denied 4 full 5 badop
  localparam vecT VECS [15] = '{
    '{4'd2,  3'd0, 8'd1, 64'd0,       4'd0, 64'd0,      4'd0, 2'd1, 3'd0, 64'd0},      // R2
    '{4'd2,  3'd0, 8'd2, 64'd0,       4'd0, 64'd0,      4'd0, 2'd0, 3'd0, 64'd1},      // R2
    '{4'd3,  3'd1, 8'd1, 64'd0,       4'd3, 64'hA5A5,   4'd1, 2'd0, 3'd0, 64'd0},      // R3
    '{4'd4,  3'd1, 8'd2, 64'd0,       4'd3, 64'hDEAD,   4'd1, 2'd0, 3'd3, 64'd0},      // R4
    '{4'd3,  3'd3, 8'd1, 64'd0,       4'd3, 64'd0,      4'd0, 2'd0, 3'd0, 64'hA5A5},   // R3
    '{4'd5,  3'd3, 8'd2, 64'd0,       4'd3, 64'd0,      4'd0, 2'd0, 3'd3, 64'd0},      // R5
    '{4'd7,  3'd4, 8'd9, 64'd0,       4'd0, 64'd0,      4'd0, 2'd0, 3'd0, 64'd2},      // R7
    '{4'd4,  3'd2, 8'd2, 64'd0,       4'd0, 64'd0,      4'd0, 2'd0, 3'd3, 64'd0},      // R4
    '{4'd4,  3'd2, 8'd1, 64'd0,       4'd0, 64'd0,      4'd0, 2'd0, 3'd0, 64'd0},      // R4
    '{4'd4,  3'd1, 8'd1, 64'd0,       4'd3, 64'hBEEF,   4'd1, 2'd0, 3'd3, 64'd0},      // R4
    '{4'd5,  3'd3, 8'd2, 64'd0,       4'd3, 64'd0,      4'd0, 2'd0, 3'd0, 64'hA5A5},   // R5
    '{4'd6,  3'd3, 8'd1, 64'h1 << 40, 4'd0, 64'd0,      4'd0, 2'd0, 3'd1, 64'd0},      // R6
    '{4'd6,  3'd3, 8'd1, 64'd5,       4'd0, 64'd0,      4'd0, 2'd0, 3'd2, 64'd0},      // R6
    '{4'd6,  3'd7, 8'd1, 64'd0,       4'd0, 64'd0,      4'd0, 2'd0, 3'd5, 64'd0},      // R6
    '{4'd7,  3'd5, 8'd1, 64'd0,       4'd0, 64'd0,      4'd0, 2'd0, 3'd0, 64'd1}       // R7
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqOp = '0;
  logic [7:0]  reqTask = '0;
  logic [63:0] reqHandle = '0;
  logic [3:0]  reqWord = '0;
  logic [63:0] reqData = '0;
  logic [3:0]  reqTag = '0;
  logic [1:0]  reqKind = '0;
  logic        rspValid;
  logic [2:0]  rspStatus;
  logic [63:0] rspData;
  logic [3:0]  rspTag;
  logic [1:0]  rspKind;
  logic        decValid;
  logic        decReady = 1'b0;
  logic [63:0] decHandle;

  int checks = 0;
  int failures = 0;
  logic        gotValid;
  logic [2:0]  gotStatus;
  logic [63:0] gotData;
  logic [3:0]  gotTag;
  logic [1:0]  gotKind;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrOnceChunkStore dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqTask(reqTask), .reqHandle(reqHandle), .reqWord(reqWord),
    .reqData(reqData), .reqTag(reqTag), .reqKind(reqKind),
    .rspValid(rspValid), .rspStatus(rspStatus), .rspData(rspData),
    .rspTag(rspTag), .rspKind(rspKind),
    .decValid(decValid), .decReady(decReady), .decHandle(decHandle)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [2:0] op, input logic [7:0] tsk, input logic [63:0] h,
                       input logic [3:0] w, input logic [63:0] d, input logic [3:0] tg,
                       input logic [1:0] k);
    reqOp = op; reqTask = tsk; reqHandle = h; reqWord = w;
    reqData = d; reqTag = tg; reqKind = k; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid  = 1'b0;
    gotValid  = rspValid;
    gotStatus = rspStatus;
    gotData   = rspData;
    gotTag    = rspTag;
    gotKind   = rspKind;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] seen [4];
    int nSeen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reqReady", 64'(reqReady), 64'd1);
    check("R1 rspValid", 64'(rspValid), 64'd0);
    check("R1 decValid", 64'(decValid), 64'd0);

    foreach (VECS[i]) begin
      doReq(VECS[i].op, VECS[i].tsk, VECS[i].handle, VECS[i].word,
            VECS[i].data, VECS[i].tag, VECS[i].kind);
      check($sformatf("R%0d vec%0d valid", VECS[i].reqNum, i), 64'(gotValid), 64'd1);
      check($sformatf("R%0d vec%0d status", VECS[i].reqNum, i), 64'(gotStatus), 64'(VECS[i].expStatus));
      check($sformatf("R%0d vec%0d data", VECS[i].reqNum, i), gotData, VECS[i].expData);
    end

    // R10: no response in the cycle after the response cycle
    @(negedge clk);
    check("R10 single response", 64'(rspValid), 64'd0);

    // R3 tag and kind read back by owner (chunk 0, kind 1, tag 1)
    doReq(3'd3, 8'd1, 64'd0, 4'd3, 64'd0, 4'd0, 2'd0);
    check("R3 tag", 64'(gotTag), 64'd1);
    check("R3 kind", 64'(gotKind), 64'd1);

    // chunk 1 (owner 2): handle words 2 and 7, data word 5
    doReq(3'd1, 8'd2, 64'd1, 4'd2, 64'h30, 4'b0100, 2'd0);
    check("R3 write handle word", 64'(gotStatus), 64'd0);
    doReq(3'd1, 8'd2, 64'd1, 4'd5, 64'h99, 4'b0001, 2'd0);
    doReq(3'd1, 8'd2, 64'd1, 4'd7, 64'h11, 4'b1000, 2'd0);
    doReq(3'd5, 8'd2, 64'd1, 4'd0, 64'd0, 4'd0, 2'd0);
    check("R7 decrement to zero", gotData, 64'd0);

    // R9 walk: first handle word held while decReady is low
    nSeen = 0;
    for (int t = 0; t < 40 && !decValid; t++) @(negedge clk);
    check("R9 first handle", decHandle, 64'h30);
    repeat (3) @(negedge clk);
    check("R9 held valid", 64'(decValid), 64'd1);
    check("R9 held handle", decHandle, 64'h30);
    check("R9 reqReady low", 64'(reqReady), 64'd0);
    decReady = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 40 && !reqReady; t++) begin
      if (decValid && nSeen < 4) begin
        seen[nSeen] = decHandle;
        nSeen++;
      end
      @(negedge clk);
    end
    check("R9 remaining handle count", 64'(nSeen), 64'd1);
    check("R9 second handle", seen[0], 64'h11);
    decReady = 1'b0;

    // R8 freed handle
    doReq(3'd3, 8'd2, 64'd1, 4'd2, 64'd0, 4'd0, 2'd0);
    check("R8 read freed", 64'(gotStatus), 64'd2);
    doReq(3'd0, 8'd3, 64'd0, 4'd0, 64'd0, 4'd0, 2'd2);
    check("R8 handle reused", gotData, 64'd1);

    // R2 fill pool then overflow
    for (int h = 2; h < 64; h++) begin
      doReq(3'd0, 8'd4, 64'd0, 4'd0, 64'd0, 4'd0, 2'd0);
      if (gotStatus !== 3'd0 || gotData !== 64'(h)) begin
        check("R2 sequential alloc", gotData, 64'(h));
      end
    end
    checks++;
    doReq(3'd0, 8'd4, 64'd0, 4'd0, 64'd0, 4'd0, 2'd0);
    check("R2 pool full", 64'(gotStatus), 64'd4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule